// File: doc/BRIEF.md
# Receive Control Character Filter with Transmit Freeze

This block sits between the byte output of a serial receiver and the logic that writes receive buffers. Every arriving byte is compared against an eight-entry programmable table of control characters. Each entry has its own enable and reject settings. A byte that hits an accepting entry is stored, and the current buffer is then closed. A byte that hits a rejecting entry is kept out of the data stream. That byte is latched into a control-character register instead, and a level interrupt is raised. Bytes that hit nothing are stored unchanged. A buffer also closes when it reaches its capacity, and a status bit marks that case.

A separate transmit path has a freeze control. The path holds one byte between the upstream source and the shifter. While the freeze is set, no new byte is handed to the shifter and the upstream handshake stalls. A byte already in the shifter finishes. Releasing the freeze continues with the held byte, so no byte is skipped or sent twice.

Typical use: software programs an end-of-line character as accepting, so that each line lands in its own buffer. It programs the flow-control stop and go characters as rejecting and drives the freeze from them.

Top module: `rx_ctl_char_filter`

## Requirements
- R1: After reset every table entry is disabled (its empty flag is 1), `buf_wr`, `buf_close`, `buf_full`, `rx_irq`, `cc_irq`, `cc_ovr` and `sh_load` are 0, and `tx_ready` is 1 while `tx_freeze` is 0.
- R2: A received byte that matches no entry whose empty flag is 0 produces `buf_wr`=1 with `buf_data` equal to the byte, one clock after `rx_valid`, with `buf_close`=0 unless the buffer becomes full.
- R3: A received byte that matches an enabled entry with reject flag 0 is written, and `buf_close` is 1 in the same cycle as that write.
- R4: A received byte that matches an enabled entry with reject flag 1 is not written. One clock later `cc_char` holds the byte and `cc_irq` is 1.
- R5: `cc_irq` stays 1 until `cc_clr` is pulsed. A rejected match while `cc_irq` is pending overwrites `cc_char` and sets `cc_ovr`. `cc_clr` clears both `cc_irq` and `cc_ovr`.
- R6: When several enabled entries match, the entry with the lowest index decides between accept and reject.
- R7: The write that brings a buffer to BUF_LEN bytes carries `buf_close`=1 and `buf_full`=1. The next byte starts a new buffer. `buf_full` is 0 for closes caused by a control character.
- R8: `rx_irq` goes to 1 one clock after each buffer close and stays 1 until `rx_clr` is pulsed. It does not respond to individual bytes.
- R9: While `tx_freeze` is 1, `tx_ready` is 0 and no `sh_load` occurs. After release the held bytes reach the shifter in their original order, with none lost or repeated.
- R10: `sh_load` never occurs while `sh_busy` is 1, so a byte already in the shifter completes undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 3 | Entry index to write |
| cfg_char | input | 8 | Character value for the entry |
| cfg_empty | input | 1 | 1 disables the entry |
| cfg_reject | input | 1 | 1 diverts matches away from the buffer |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| buf_wr | output | 1 | Buffer write strobe |
| buf_data | output | 8 | Byte to write |
| buf_close | output | 1 | End-of-buffer strobe, with the last write |
| buf_full | output | 1 | Close was caused by the buffer reaching capacity |
| rx_irq | output | 1 | Buffer-closed interrupt, level |
| rx_clr | input | 1 | Clears `rx_irq` |
| cc_irq | output | 1 | Control-character interrupt, level |
| cc_char | output | 8 | Last rejected control character |
| cc_ovr | output | 1 | A rejected match arrived while `cc_irq` was pending |
| cc_clr | input | 1 | Clears `cc_irq` and `cc_ovr` |
| tx_freeze | input | 1 | Halts transmission at a byte boundary |
| tx_valid | input | 1 | Upstream transmit byte available |
| tx_data | input | 8 | Upstream transmit byte |
| tx_ready | output | 1 | Transmit byte accepted this cycle when valid |
| sh_busy | input | 1 | Shifter is sending a byte |
| sh_load | output | 1 | Hands `sh_data` to the shifter |
| sh_data | output | 8 | Byte for the shifter |

## Verification
The checker covers the rules that hold on every cycle. A close always comes with a write, and a full flag only comes with a close. A pending control interrupt never drops without a clear, and overrun never shows without the interrupt. No load happens after a frozen cycle or onto a busy shifter, and the handshake is never ready while frozen. The bench scenarios are needed for what depends on history and data. These are the lowest-index priority between conflicting entries, the exact byte count at which a full close happens, the overwrite of the latched character, and the claim that the transmit sequence after a freeze is complete and in order.

// File: rtl/ucc_pkg.sv
package ucc_pkg;
  localparam int CHW = 8;

  typedef struct packed {
    logic           empty;
    logic           reject;
    logic [CHW-1:0] ch;
  } cc_entry_t;
endpackage

// File: rtl/cc_table.sv
module cc_table
  import ucc_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [CHW-1:0] cfg_char,
  input  logic           cfg_empty,
  input  logic           cfg_reject,
  input  logic [CHW-1:0] probe,
  output logic           hit,
  output logic           hit_rej
);
  cc_entry_t        ent   [N];
  cc_entry_t        ent_n [N];
  logic [N-1:0]     mv;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_comb begin
      ent_n[i] = ent[i];
      if (cfg_we && (cfg_idx == IW'(i))) begin
        ent_n[i].empty  = cfg_empty;
        ent_n[i].reject = cfg_reject;
        ent_n[i].ch     = cfg_char;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[i].empty  <= 1'b1;
        ent[i].reject <= 1'b0;
        ent[i].ch     <= '0;
      end else if (cfg_we) begin
        ent[i] <= ent_n[i];
      end
    end

    assign mv[i] = !ent[i].empty && (ent[i].ch == probe);
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    hit     = 1'b0;
    hit_rej = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mv[i]) begin
        hit     = 1'b1;
        hit_rej = ent[i].reject;
      end
    end
  end
endmodule

// File: rtl/rx_path.sv
module rx_path
  import ucc_pkg::*;
#(
  parameter int BUF_LEN = 16,
  localparam int CW = $clog2(BUF_LEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_valid,
  input  logic [CHW-1:0] rx_byte,
  input  logic           hit,
  input  logic           hit_rej,
  input  logic           rx_clr,
  input  logic           cc_clr,
  output logic           buf_wr,
  output logic [CHW-1:0] buf_data,
  output logic           buf_close,
  output logic           buf_full,
  output logic           rx_irq,
  output logic           cc_irq,
  output logic [CHW-1:0] cc_char,
  output logic           cc_ovr
);
  logic [CW-1:0]  cnt, cnt_n;
  logic           wr_n, close_n, full_n, rxirq_n, ccirq_n, ovr_n;
  logic [CHW-1:0] data_n, ccchar_n;
  logic           last;

  assign last = (cnt == CW'(BUF_LEN - 1));

  always_comb begin
    wr_n     = 1'b0;
    close_n  = 1'b0;
    full_n   = 1'b0;
    cnt_n    = cnt;
    data_n   = buf_data;
    ccchar_n = cc_char;
    rxirq_n  = rx_irq & ~rx_clr;
    ccirq_n  = cc_irq & ~cc_clr;
    ovr_n    = cc_ovr & ~cc_clr;
    if (rx_valid) begin
      if (hit && hit_rej) begin
        ccchar_n = rx_byte;
        ovr_n    = cc_irq & ~cc_clr;
        ccirq_n  = 1'b1;
      end else begin
        wr_n   = 1'b1;
        data_n = rx_byte;
        if (hit || last) begin
          close_n = 1'b1;
          full_n  = last;
          cnt_n   = '0;
          rxirq_n = 1'b1;
        end else begin
          cnt_n = cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_wr    <= 1'b0;
      buf_close <= 1'b0;
      buf_full  <= 1'b0;
      cnt       <= '0;
      rx_irq    <= 1'b0;
      cc_irq    <= 1'b0;
      cc_ovr    <= 1'b0;
    end else begin
      buf_wr    <= wr_n;
      buf_close <= close_n;
      buf_full  <= full_n;
      cnt       <= cnt_n;
      rx_irq    <= rxirq_n;
      cc_irq    <= ccirq_n;
      cc_ovr    <= ovr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    buf_data <= '0;
    else if (wr_n) buf_data <= data_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cc_char <= '0;
    else if (rx_valid && hit_rej) cc_char <= ccchar_n;
  end
endmodule

// File: rtl/tx_gate.sv
module tx_gate
  import ucc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_freeze,
  input  logic           tx_valid,
  input  logic [CHW-1:0] tx_data,
  output logic           tx_ready,
  input  logic           sh_busy,
  output logic           sh_load,
  output logic [CHW-1:0] sh_data
);
  logic           hold_full, hold_n;
  logic [CHW-1:0] hold_data;
  logic           accept, launch;

  assign tx_ready = !hold_full && !tx_freeze;
  assign accept   = tx_valid && tx_ready;
  assign launch   = hold_full && !sh_busy && !tx_freeze && !sh_load;

  always_comb begin
    hold_n = hold_full;
    if (launch) hold_n = 1'b0;
    if (accept) hold_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      sh_load   <= 1'b0;
    end else begin
      hold_full <= hold_n;
      sh_load   <= launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_data <= '0;
    else if (accept) hold_data <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_data <= '0;
    else if (launch) sh_data <= hold_data;
  end
endmodule

// File: rtl/rx_ctl_char_filter.sv
module rx_ctl_char_filter
  import ucc_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int BUF_LEN = 16,
  localparam int IW = $clog2(N_ENT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [CHW-1:0] cfg_char,
  input  logic           cfg_empty,
  input  logic           cfg_reject,
  input  logic           rx_valid,
  input  logic [CHW-1:0] rx_byte,
  output logic           buf_wr,
  output logic [CHW-1:0] buf_data,
  output logic           buf_close,
  output logic           buf_full,
  output logic           rx_irq,
  input  logic           rx_clr,
  output logic           cc_irq,
  output logic [CHW-1:0] cc_char,
  output logic           cc_ovr,
  input  logic           cc_clr,
  input  logic           tx_freeze,
  input  logic           tx_valid,
  input  logic [CHW-1:0] tx_data,
  output logic           tx_ready,
  input  logic           sh_busy,
  output logic           sh_load,
  output logic [CHW-1:0] sh_data
);
  logic hit, hit_rej;

  cc_table #(.N(N_ENT)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_char(cfg_char),
    .cfg_empty(cfg_empty), .cfg_reject(cfg_reject),
    .probe(rx_byte), .hit(hit), .hit_rej(hit_rej)
  );

  rx_path #(.BUF_LEN(BUF_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .hit(hit), .hit_rej(hit_rej),
    .rx_clr(rx_clr), .cc_clr(cc_clr),
    .buf_wr(buf_wr), .buf_data(buf_data), .buf_close(buf_close),
    .buf_full(buf_full), .rx_irq(rx_irq), .cc_irq(cc_irq),
    .cc_char(cc_char), .cc_ovr(cc_ovr)
  );

  tx_gate u_tx (
    .clk(clk), .rst_n(rst_n), .tx_freeze(tx_freeze),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .sh_busy(sh_busy), .sh_load(sh_load), .sh_data(sh_data)
  );
endmodule

// File: rtl/rx_ctl_char_filter_chk.sv
module rx_ctl_char_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic buf_wr,
  input logic buf_close,
  input logic buf_full,
  input logic rx_irq,
  input logic rx_clr,
  input logic cc_irq,
  input logic cc_ovr,
  input logic cc_clr,
  input logic tx_freeze,
  input logic tx_ready,
  input logic sh_busy,
  input logic sh_load
);
  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !buf_wr);
  p_close_has_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |-> buf_wr);
  p_irq_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_irq && !cc_clr) |=> cc_irq);
  p_ovr_needs_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_ovr |-> cc_irq);
  p_full_is_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> buf_close);
  p_rx_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !rx_clr) |=> rx_irq);
  p_freeze_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_freeze |=> !sh_load);
  p_freeze_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_freeze |-> !tx_ready);
  p_busy_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |=> !sh_load);
endmodule

bind rx_ctl_char_filter rx_ctl_char_filter_chk u_chk (.*);

// File: tb/sim_rx_ctl_char_filter.sv
module sim_rx_ctl_char_filter;
  localparam int PER = 10;
  localparam int BL  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_empty = 0, cfg_reject = 0;
  logic [2:0] cfg_idx = 0;
  logic [7:0] cfg_char = 0, rx_byte = 0, tx_data = 0, buf_data, cc_char, sh_data;
  logic rx_valid = 0, rx_clr = 0, cc_clr = 0, tx_freeze = 0, tx_valid = 0;
  logic buf_wr, buf_close, buf_full, rx_irq, cc_irq, cc_ovr, tx_ready, sh_load, sh_busy;

  int checks = 0, errors = 0;

  // bench-side table and expected state
  bit       m_empty [8];
  bit       m_rej   [8];
  bit [7:0] m_ch    [8];
  int       bcnt = 0;
  bit       e_ccirq = 0, e_ovr = 0, e_rxirq = 0;
  bit [7:0] e_ccchar = 0;

  // shifter model and transmit monitor
  int       sh_cnt = 0;
  bit       frz_d = 0;
  int       n_rec = 0, busy_viol = 0, frz_viol = 0;
  bit [7:0] rec [16];

  always #(PER/2) clk = ~clk;
  assign sh_busy = (sh_cnt != 0);

  rx_ctl_char_filter #(.N_ENT(8), .BUF_LEN(BL)) u0 (.*);

  always @(posedge clk) begin
    frz_d <= tx_freeze;
    if (sh_load) begin
      if (sh_cnt != 0) busy_viol++;
      if (frz_d) frz_viol++;
      if (n_rec < 16) rec[n_rec] = sh_data;
      n_rec++;
      sh_cnt <= 3;
    end else if (sh_cnt != 0) begin
      sh_cnt <= sh_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input bit [7:0] ch, input bit emp, input bit rej);
    cfg_we = 1; cfg_idx = idx[2:0]; cfg_char = ch; cfg_empty = emp; cfg_reject = rej;
    @(negedge clk);
    cfg_we = 0;
    m_empty[idx] = emp; m_rej[idx] = rej; m_ch[idx] = ch;
  endtask

  // sends one byte and checks every receive output against the bench model
  task automatic rx_send(input bit [7:0] b, input string req);
    bit hit = 0, rej = 0, wr, cl, fu;
    for (int i = 7; i >= 0; i--)
      if (!m_empty[i] && m_ch[i] == b) begin hit = 1; rej = m_rej[i]; end
    wr = !(hit && rej); cl = 0; fu = 0;
    if (hit && rej) begin
      e_ovr = e_ccirq; e_ccirq = 1; e_ccchar = b;
    end else if (hit || bcnt == BL - 1) begin
      cl = 1; fu = (bcnt == BL - 1); bcnt = 0; e_rxirq = 1;
    end else bcnt++;
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
    chk(buf_wr == wr, req, "buf_wr", buf_wr, wr);
    if (wr) chk(buf_data == b, req, "buf_data", buf_data, b);
    chk(buf_close == cl, req, "buf_close", buf_close, cl);
    chk(buf_full == fu, req, "buf_full", buf_full, fu);
    chk(rx_irq == e_rxirq, req, "rx_irq", rx_irq, e_rxirq);
    chk(cc_irq == e_ccirq, req, "cc_irq", cc_irq, e_ccirq);
    chk(cc_ovr == e_ovr, req, "cc_ovr", cc_ovr, e_ovr);
    chk(cc_char == e_ccchar, req, "cc_char", cc_char, e_ccchar);
  endtask

  task automatic clear_cc();
    cc_clr = 1; @(negedge clk); cc_clr = 0;
    e_ccirq = 0; e_ovr = 0;
    chk(cc_irq == 0 && cc_ovr == 0, "R5", "cc clear", {cc_irq, cc_ovr}, 0);
  endtask

  task automatic clear_rx();
    rx_clr = 1; @(negedge clk); rx_clr = 0;
    e_rxirq = 0;
    chk(rx_irq == 0, "R8", "rx_irq clear", rx_irq, 0);
  endtask

  task automatic t_reset();
    chk(!buf_wr && !buf_close && !buf_full, "R1", "buffer outputs", {buf_wr, buf_close, buf_full}, 0);
    chk(!rx_irq && !cc_irq && !cc_ovr, "R1", "interrupts", {rx_irq, cc_irq, cc_ovr}, 0);
    chk(!sh_load && tx_ready, "R1", "tx idle", {sh_load, tx_ready}, 1);
    rx_send(8'h0A, "R1");  // every entry starts disabled
  endtask

  task automatic t_plain();
    cfg(6, 8'h23, 1, 0);   // entry disabled: its character is ordinary data
    rx_send(8'h23, "R2");
    rx_send(8'h41, "R2");
    rx_send(8'h00, "R2");
    repeat (2) @(negedge clk);
    chk(buf_wr == 0, "R2", "idle write", buf_wr, 0);
  endtask

  task automatic t_close();
    cfg(2, 8'h0A, 0, 0);
    rx_send(8'h53, "R3");
    rx_send(8'h31, "R3");
    rx_send(8'h0A, "R3");
    repeat (3) @(negedge clk);
    chk(rx_irq == 1, "R8", "rx_irq held", rx_irq, 1);
    clear_rx();
    rx_send(8'h32, "R8");
    chk(rx_irq == 0, "R8", "no irq per byte", rx_irq, 0);
  endtask

  task automatic t_reject();
    cfg(0, 8'h13, 0, 1);
    cfg(1, 8'h11, 0, 1);
    rx_send(8'h13, "R4");
    repeat (3) @(negedge clk);
    chk(cc_irq == 1, "R5", "cc_irq held", cc_irq, 1);
    rx_send(8'h78, "R4");
    rx_send(8'h11, "R5");
    clear_cc();
    rx_send(8'h11, "R5");
    clear_cc();
  endtask

  task automatic t_priority();
    cfg(5, 8'h7E, 0, 0);
    cfg(3, 8'h7E, 0, 1);
    rx_send(8'h7E, "R6");   // entry 3 rejects
    clear_cc();
    cfg(3, 8'h7E, 1, 1);
    rx_send(8'h7E, "R6");   // only entry 5 left: closes
    clear_rx();
  endtask

  task automatic t_full();
    chk(bcnt == 0, "R7", "bench buffer start", bcnt, 0);
    for (int i = 0; i < BL + 2; i++) rx_send(8'h60 + 8'(i), "R7");
    clear_rx();
  endtask

  task automatic tx_push(input bit [7:0] b);
    bit got = 0;
    tx_valid = 1; tx_data = b;
    while (!got) begin
      #1 got = tx_ready;
      @(negedge clk);
    end
    tx_valid = 0;
  endtask

  task automatic t_tx();
    int snap;
    fork
      begin
        for (int i = 0; i < 8; i++) tx_push(8'hA0 + 8'(i));
      end
      begin
        repeat (9) @(negedge clk);
        tx_freeze = 1;
        repeat (5) @(negedge clk);
        snap = n_rec;
        chk(tx_ready == 0, "R9", "ready while frozen", tx_ready, 0);
        repeat (20) @(negedge clk);
        chk(n_rec == snap, "R9", "loads while frozen", n_rec, snap);
        tx_freeze = 0;
      end
    join
    repeat (40) @(negedge clk);
    chk(n_rec == 8, "R9", "byte count", n_rec, 8);
    for (int i = 0; i < 8; i++)
      chk(rec[i] == 8'hA0 + 8'(i), "R9", "byte order", rec[i], 8'hA0 + i);
    chk(frz_viol == 0, "R9", "load after frozen cycle", frz_viol, 0);
    chk(busy_viol == 0, "R10", "load onto busy shifter", busy_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_empty[i] = 1; m_rej[i] = 0; m_ch[i] = 0; end
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_close();
        t_reject();
        t_priority();
        t_full();
        t_tx();
      end
      begin
        repeat (150000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule